// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides an unsigned dividend by an unsigned divisor of the same width (8 bits by default) and returns a quotient and a remainder. It works by the restoring method. Each clock step shifts the partial remainder left and appends the next dividend bit, taken from the most significant end. The step then tests whether this trial value reaches the divisor, and keeps either the trial value or the trial minus the divisor. Each step yields one quotient bit, most significant first. A full operation always takes exactly W steps.

The trial test is a single signed weighted sum: each trial bit contributes plus its binary weight, each divisor bit contributes minus its weight, and the test passes when the sum is not negative. A per-bit AND-OR selector, steered by the test result and its inverse, restores the kept value. Operands enter over a valid/ready handshake. in_ready is low for as long as the block is busy, and an in_valid that arrives then is dropped, not queued. The output side has no back-pressure: out_valid is a one-cycle pulse, and the registered quotient and remainder stay unchanged until the next operation completes. A zero divisor is not an error. It gives an all-ones quotient and a remainder equal to the dividend.

Top module: `seq_restoring_divider`

## Requirements
- R1: While the block is idle, in_ready is 1. An edge that sees in_valid=1 and in_ready=1 captures dividend and divisor, and busy reads 1 in the next cycle.
- R2: When operands are accepted at edge k, busy stays 1 and out_valid stays 0 through the cycle after edge k+7. out_valid is 1 and busy is 0 in the cycle after edge k+8.
- R3: When the divisor is non-zero, the quotient presented with out_valid is floor(dividend / divisor).
- R4: When the divisor is non-zero, the remainder presented with out_valid is dividend mod divisor and is below the divisor.
- R5: A zero divisor gives quotient 0xFF (all ones) and a remainder equal to the dividend. No other indication is given.
- R6: An in_valid that arrives while busy is 1 is ignored. The running operation's result and timing do not change, and no second result follows.
- R7: out_valid is high for exactly one cycle. quotient and remainder hold their values until the next completion.
- R8: A new operation can be accepted in the same cycle that out_valid is high, and the result just presented is not disturbed.
- R9: After reset, busy=0, in_ready=1, out_valid=0, quotient=0 and remainder=0.
- R10: While an operation runs with a non-zero divisor, the partial remainder stays strictly below the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Block can take operands (idle) |
| dividend | input | W (8) | Unsigned dividend |
| divisor | input | W (8) | Unsigned divisor |
| busy | output | 1 | Division in progress |
| out_valid | output | 1 | One-cycle pulse: results valid |
| quotient | output | W (8) | Registered quotient |
| remainder | output | W (8) | Registered remainder |

## Verification
Two functions can land in the same cycle: presenting a finished result and accepting the next operands. The bench provokes this by raising in_valid in the very cycle out_valid is high. It then checks that the old quotient and remainder stay visible during the next run, and that the chained operation completes exactly 9 cycles later with its own correct result. A second case overlaps a running division with a stray in_valid. Here the bench checks that the result and the completion timing match the original operands.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} div_phase_e;
endpackage

// File: rtl/div_trial_cmp.sv
// Trial >= divisor decided by one signed positional-weight sum.
module div_trial_cmp #(
  parameter int W = 8
) (
  input  logic [W:0]   trial,
  input  logic [W-1:0] dsr,
  output logic         ge
);
  localparam int SW = W + 3;

  logic signed [SW-1:0] psum [0:W+1];
  assign psum[0] = '0;

  for (genvar i = 0; i <= W; i++) begin : g_term
    localparam logic signed [SW-1:0] WT = {{(SW-1){1'b0}}, 1'b1} << i;
    logic signed [SW-1:0] plus_t, minus_t;
    assign plus_t = trial[i] ? WT : '0;
    if (i < W) begin : g_dsr
      assign minus_t = dsr[i] ? WT : '0;
    end else begin : g_top
      assign minus_t = '0;
    end
    assign psum[i+1] = psum[i] + plus_t - minus_t;
  end

  assign ge = ~psum[W+1][SW-1];
endmodule

// File: rtl/div_restore_mux.sv
// Per-bit AND-OR selector: keep when the test fails, difference when it passes.
module div_restore_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] keep,
  input  logic [W-1:0] diff,
  input  logic         pass,
  output logic [W-1:0] pick
);
  logic no_pass;
  assign no_pass = ~pass;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic take_keep, take_diff;
    assign take_keep = keep[i] & no_pass;
    assign take_diff = diff[i] & pass;
    assign pick[i]   = take_keep | take_diff;
  end
endmodule

// File: rtl/div_step.sv
// One restoring iteration: shift in a bit, test, conditionally subtract.
module div_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] rem_in,
  input  logic         bit_in,
  input  logic [W-1:0] dsr,
  output logic [W-1:0] rem_out,
  output logic         q_bit
);
  logic [W:0] trial;
  logic [W:0] trial_minus;

  assign trial       = {rem_in, bit_in};
  assign trial_minus = trial - {1'b0, dsr};

  div_trial_cmp #(.W(W)) u_cmp (
    .trial (trial),
    .dsr   (dsr),
    .ge    (q_bit)
  );

  div_restore_mux #(.W(W)) u_mux (
    .keep  (trial[W-1:0]),
    .diff  (trial_minus[W-1:0]),
    .pass  (q_bit),
    .pick  (rem_out)
  );
endmodule

// File: rtl/seq_restoring_divider.sv
module seq_restoring_divider
  import div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         out_valid,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_phase_e    phase_q;
  logic [CW-1:0] step_q;
  logic [W-1:0]  rem_q, work_q, dsr_q, quo_q, rmd_q;
  logic          ov_q;
  logic [W-1:0]  rem_nxt;
  logic          q_bit;
  logic          accept;

  assign busy      = (phase_q == PH_RUN);
  assign in_ready  = ~busy;
  assign accept    = in_valid & in_ready;
  assign out_valid = ov_q;
  assign quotient  = quo_q;
  assign remainder = rmd_q;

  div_step #(.W(W)) u_step (
    .rem_in  (rem_q),
    .bit_in  (work_q[W-1]),
    .dsr     (dsr_q),
    .rem_out (rem_nxt),
    .q_bit   (q_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      rem_q   <= '0;
      work_q  <= '0;
      dsr_q   <= '0;
      quo_q   <= '0;
      rmd_q   <= '0;
      ov_q    <= 1'b0;
    end else begin
      ov_q <= 1'b0;
      if (accept) begin
        phase_q <= PH_RUN;
        step_q  <= '0;
        rem_q   <= '0;
        work_q  <= dividend;
        dsr_q   <= divisor;
      end else if (phase_q == PH_RUN) begin
        rem_q  <= rem_nxt;
        work_q <= {work_q[W-2:0], q_bit};
        step_q <= step_q + 1'b1;
        if (step_q == LAST) begin
          phase_q <= PH_IDLE;
          quo_q   <= {work_q[W-2:0], q_bit};
          rmd_q   <= rem_nxt;
          ov_q    <= 1'b1;
        end
      end
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy); // R1
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy) && !busy); // R2
  AST_BOUND_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dsr_q != '0 |-> remainder < dsr_q); // R4
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dsr_q == '0 |-> quotient == '1); // R5
  AST_BUSY_HOLDS_DSR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dsr_q)); // R6
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(quotient) && $stable(remainder)); // R7
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dsr_q != '0 |-> rem_q < dsr_q); // R10
endmodule

// File: tb/sim_seq_restoring_divider.sv
`timescale 1ns/1ps
module sim_seq_restoring_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] dividend = '0, divisor = '0;
  logic       busy, out_valid;
  logic [7:0] quotient, remainder;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] prev_q = 8'h00, prev_r = 8'h00;

  always #2.5 clk = ~clk;

  seq_restoring_divider #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .busy(busy),
    .out_valid(out_valid), .quotient(quotient), .remainder(remainder)
  );

  function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] b);
    if (b == 8'd0) return {8'hFF, a};
    return {a / b, a % b};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Caller stands away from a rising edge; operands accepted at the next edge.
  task automatic launch(input logic [7:0] a, input logic [7:0] b);
    in_valid = 1'b1; dividend = a; divisor = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Runs from just after the accepting edge to the out_valid cycle.
  task automatic finish(input logic [7:0] a, input logic [7:0] b, input bit ign);
    logic [15:0] e;
    e = model(a, b);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k == 0) begin
        chk("R1 busy after accept", {15'd0, busy}, 16'd1);
        chk("R7/R8 result held", {quotient, remainder}, {prev_q, prev_r});
      end
      if (ign && k == 2) begin
        in_valid = 1'b1; dividend = ~a; divisor = b + 8'd3;   // R6 stray offer
      end else begin
        in_valid = 1'b0;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 still running", {14'd0, busy, out_valid}, 16'b10);
    @(posedge clk);
    @(negedge clk);
    chk("R2 done timing", {14'd0, busy, out_valid}, 16'b01);
    if (b == 8'd0) chk("R5 zero divisor", {quotient, remainder}, e);
    else begin
      chk("R3 quotient", {8'd0, quotient}, {8'd0, e[15:8]});
      chk("R4 remainder", {8'd0, remainder}, {8'd0, e[7:0]});
    end
    if (ign) chk("R6 ignored offer", {quotient, remainder}, e);
    prev_q = quotient; prev_r = remainder;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R2 actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] da [10] = '{8'd200, 8'd255, 8'd0,  8'd7,   8'd255, 8'd100, 8'd0, 8'd255, 8'd128, 8'd254};
    logic [7:0] db [10] = '{8'd7,   8'd1,   8'd5,  8'd200, 8'd255, 8'd0,   8'd0, 8'd0,   8'd2,   8'd255};
    logic [7:0] a, b;
    bit ign, chain;
    void'($urandom(32'd2024));
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset outputs", {busy, in_ready, out_valid, 13'd0}, {3'b010, 13'd0});
    chk("R9 reset results", {quotient, remainder}, 16'h0000);
    chk("R1 ready idle", {15'd0, in_ready}, 16'd1);
    for (int i = 0; i < 70; i++) begin
      if (i < 10) begin
        a = da[i]; b = db[i]; ign = (i % 3 == 2); chain = (i % 2 == 1);
      end else begin
        a = 8'($urandom);
        case ($urandom % 4)
          0: b = 8'd0;
          1: b = 8'($urandom % 16);
          default: b = 8'($urandom);
        endcase
        ign = ($urandom % 3 == 0); chain = ($urandom % 2 == 1);
      end
      launch(a, b);
      finish(a, b, ign);
      if (!chain) begin
        @(negedge clk);
        chk("R7 one-cycle pulse", {15'd0, out_valid}, 16'd0);
        chk("R7 hold after pulse", {quotient, remainder}, {prev_q, prev_r});
        if (ign) chk("R6 no second result", {15'd0, busy}, 16'd0);
      end else begin
        chk("R8 ready during done", {15'd0, in_ready}, 16'd1);
      end
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule